// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a real address through a small bank of block-translation entries. Each entry is a pair of 32-bit words, an upper word and a lower word. The bank holds one set of entries for instruction fetches and a separate set for loads and stores. A lookup compares the effective address against every entry of the selected set in parallel. The lowest-numbered entry that matches supplies the real page number and the access rights. All of this is combinational, so a result is ready in the same cycle as the address.

Each entry covers a naturally aligned region of 128 KiB or larger. A length code inside the entry widens the region by dropping low-order region bits from the compare. Those dropped bits are then taken from the effective address instead of from the entry's real base. A layout-select input switches between two word formats. The formats differ in where validity, length and protection are kept, and in how protection is decoded. A miss only drops the hit flag; fault handling and any fall-back walk belong to other logic. A simple write port loads the entry words one word per cycle.

Top module: `blkx_match`

## Requirements
- R1: After reset every entry word of both sets is zero, so no lookup hits in either layout until entries are written.
- R2: When wr_en is high at a clock edge, wr_data is stored into the word chosen by wr_instr (1 = instruction set), wr_idx and wr_upper (1 = upper word). It is visible to lookups from the next cycle, and every other word keeps its value.
- R3: A lookup with is_fetch = 1 consults only the instruction set. A lookup with is_fetch = 0 consults only the data set.
- R4: In the standard layout (alt_layout = 0), an entry is valid in supervisor mode (user_mode = 0) only when upper bit 1 is set. In user mode it is valid only when upper bit 0 is set.
- R5: In the standard layout, the length code is upper bits 12:2, and upper bits 31:17 hold the region base. Each set bit i of the length code removes address bit 17+i from the compare. A hit needs the kept address bits to equal the corresponding upper-word bits, and the dropped upper-word bits to be zero.
- R6: On a hit, real_addr = bits 31:12 of ((lower & keep) | (ea & ~keep)). Here keep selects the compared region bits 31:17. Address bits 16:12 always pass through from ea.
- R7: prot is {execute, write, read}. In the standard layout it comes from lower bits 1:0: 0 gives 000, 2 gives 111, and 1 or 3 gives 101.
- R8: In the alternate layout (alt_layout = 1), an entry is valid only when lower bit 6 is set, whatever the privilege. The length code is lower bits 5:0, and it drops address bits 22:17.
- R9: In the alternate layout, the key is upper bit 3 in supervisor mode and upper bit 2 in user mode, and the protection code is upper bits 1:0. With key 0: code 3 gives read only, other codes give read and write. With key 1: code 0 gives nothing, code 2 gives read and write, codes 1 and 3 give read only. Execute is always set.
- R10: When several entries match, the lowest index supplies real_addr and prot.
- R11: On a miss hit is 0, real_addr is 0 and prot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry word this cycle |
| wr_instr | input | 1 | Write target set: 1 instruction, 0 data |
| wr_idx | input | IDX_W | Entry index to write |
| wr_upper | input | 1 | Write target word: 1 upper, 0 lower |
| wr_data | input | 32 | Word value to store |
| ea | input | 32 | Effective address to translate |
| is_fetch | input | 1 | Access is an instruction fetch |
| user_mode | input | 1 | Access is made in user mode |
| alt_layout | input | 1 | Entry words use the alternate format |
| hit | output | 1 | An entry matched |
| real_addr | output | 20 | Real page number, address bits 31:12 |
| prot | output | 3 | Rights {execute, write, read} |

## Verification
The bench uses the default of four entries per set. With that size, priority between overlapping entries, the untouched neighbours of a written word and the separation of the two sets can all be set up directly. The standard length code is swept through all twelve widths from none to eleven bits, with addresses chosen on both sides of each region edge. In the alternate layout, every combination of both key bits, all four protection codes and both privilege levels is run against three length codes. Expected results come from an arithmetic model of the requirements, which the bench keeps over its own record of the words it wrote.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int WORD_W      = 32;
  localparam int PAGE_LSB    = 12;
  localparam int RGN_LSB     = 17;
  localparam int RGN_W       = WORD_W - RGN_LSB;
  localparam int PN_W        = WORD_W - PAGE_LSB;
  localparam int OFS_W       = RGN_LSB - PAGE_LSB;
  localparam int PP_W        = 2;
  // standard layout fields
  localparam int STD_LEN_LSB = 2;
  localparam int STD_LEN_W   = 11;
  localparam int STD_SUP_V   = 1;
  localparam int STD_USR_V   = 0;
  // alternate layout fields
  localparam int ALT_LEN_W   = 6;
  localparam int ALT_V_BIT   = 6;
  localparam int ALT_KEY_SUP = 3;
  localparam int ALT_KEY_USR = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } perm_t;

  function automatic perm_t perm_plain(input logic [PP_W-1:0] code);
    perm_t p;
    p.ex = (code != 2'd0);
    p.rd = (code != 2'd0);
    p.wr = (code == 2'd2);
    return p;
  endfunction

  function automatic perm_t perm_keyed(input logic key, input logic [PP_W-1:0] code);
    perm_t p;
    p.ex = 1'b1;
    if (!key) begin
      p.rd = 1'b1;
      p.wr = (code != 2'd3);
    end else begin
      p.rd = (code != 2'd0);
      p.wr = (code == 2'd2);
    end
    return p;
  endfunction
endpackage

// File: rtl/blkx_regs.sv
module blkx_regs
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_instr,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_upper,
  input  logic [WORD_W-1:0]              wr_data,
  input  logic                           rd_instr,
  output logic [NUM_ENT-1:0][WORD_W-1:0] rd_up,
  output logic [NUM_ENT-1:0][WORD_W-1:0] rd_lo
);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_pair
    word_t iu_q, il_q, du_q, dl_q;
    logic  sel, ld_iu, ld_il, ld_du, ld_dl;

    always_comb begin
      sel   = wr_en && (wr_idx == IDX_W'(e));
      ld_iu = sel &&  wr_instr &&  wr_upper;
      ld_il = sel &&  wr_instr && !wr_upper;
      ld_du = sel && !wr_instr &&  wr_upper;
      ld_dl = sel && !wr_instr && !wr_upper;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iu_q <= '0;
        il_q <= '0;
        du_q <= '0;
        dl_q <= '0;
      end else begin
        if (ld_iu) iu_q <= wr_data;
        if (ld_il) il_q <= wr_data;
        if (ld_du) du_q <= wr_data;
        if (ld_dl) dl_q <= wr_data;
      end
    end

    assign rd_up[e] = rd_instr ? iu_q : du_q;
    assign rd_lo[e] = rd_instr ? il_q : dl_q;
  end

endmodule

// File: rtl/blkx_entry.sv
module blkx_entry
  import blkx_pkg::*;
(
  input  logic [WORD_W-1:0] up_w,
  input  logic [WORD_W-1:0] lo_w,
  input  logic [WORD_W-1:0] ea,
  input  logic              user_mode,
  input  logic              alt_layout,
  output logic              match,
  output logic [PN_W-1:0]   pn,
  output perm_t             perm
);

  logic             valid;
  logic [RGN_W-1:0] len_open;
  logic [RGN_W-1:0] keep;
  logic [RGN_W-1:0] ea_rgn, up_rgn, lo_rgn;
  logic             key;

  always_comb begin
    ea_rgn = ea[WORD_W-1:RGN_LSB];
    up_rgn = up_w[WORD_W-1:RGN_LSB];
    lo_rgn = lo_w[WORD_W-1:RGN_LSB];
    if (alt_layout) begin
      valid    = lo_w[ALT_V_BIT];
      len_open = RGN_W'(lo_w[ALT_LEN_W-1:0]);
    end else begin
      valid    = user_mode ? up_w[STD_USR_V] : up_w[STD_SUP_V];
      len_open = RGN_W'(up_w[STD_LEN_LSB +: STD_LEN_W]);
    end
    keep  = ~len_open;
    match = valid && ((ea_rgn & keep) == up_rgn);
    pn    = {(lo_rgn & keep) | (ea_rgn & ~keep), ea[RGN_LSB-1:PAGE_LSB]};
    key   = user_mode ? up_w[ALT_KEY_USR] : up_w[ALT_KEY_SUP];
    perm  = alt_layout ? perm_keyed(key, up_w[PP_W-1:0]) : perm_plain(lo_w[PP_W-1:0]);
  end

endmodule

// File: rtl/blkx_pick.sv
module blkx_pick
  import blkx_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic [NUM_ENT-1:0]           match_vec,
  input  logic [NUM_ENT-1:0][PN_W-1:0] pn_vec,
  input  logic [NUM_ENT-1:0][2:0]      perm_vec,
  output logic [NUM_ENT-1:0]           grant,
  output logic                         hit,
  output logic [PN_W-1:0]              pn,
  output logic [2:0]                   perm
);

  always_comb begin
    grant = match_vec & (~match_vec + NUM_ENT'(1));
    hit   = |match_vec;
    pn    = '0;
    perm  = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (grant[e]) begin
        pn   = pn | pn_vec[e];
        perm = perm | perm_vec[e];
      end
    end
  end

endmodule

// File: rtl/blkx_match.sv
module blkx_match
  import blkx_pkg::*;
#(
  parameter int  NUM_ENT = 4,
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_instr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_upper,
  input  logic [31:0]      wr_data,
  input  logic [31:0]      ea,
  input  logic             is_fetch,
  input  logic             user_mode,
  input  logic             alt_layout,
  output logic             hit,
  output logic [19:0]      real_addr,
  output logic [2:0]       prot
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_ENT-1:0][WORD_W-1:0] set_up, set_lo;
  logic [NUM_ENT-1:0]             match_vec, grant;
  logic [NUM_ENT-1:0][PN_W-1:0]   pn_vec;
  logic [NUM_ENT-1:0][2:0]        perm_vec;

  blkx_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_instr (wr_instr),
    .wr_idx   (wr_idx),
    .wr_upper (wr_upper),
    .wr_data  (wr_data),
    .rd_instr (is_fetch),
    .rd_up    (set_up),
    .rd_lo    (set_lo)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    perm_t ent_perm;
    blkx_entry u_ent (
      .up_w       (set_up[e]),
      .lo_w       (set_lo[e]),
      .ea         (ea),
      .user_mode  (user_mode),
      .alt_layout (alt_layout),
      .match      (match_vec[e]),
      .pn         (pn_vec[e]),
      .perm       (ent_perm)
    );
    assign perm_vec[e] = ent_perm;
  end

  blkx_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .match_vec (match_vec),
    .pn_vec    (pn_vec),
    .perm_vec  (perm_vec),
    .grant     (grant),
    .hit       (hit),
    .pn        (real_addr),
    .perm      (prot)
  );

endmodule

// File: rtl/blkx_match_chk.sv
module blkx_match_chk #(
  parameter int NUM_ENT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        ea,
  input logic               alt_layout,
  input logic               hit,
  input logic [19:0]        real_addr,
  input logic [2:0]         prot,
  input logic [NUM_ENT-1:0] match_vec,
  input logic [NUM_ENT-1:0] grant
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hit);

  p_page_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> real_addr[4:0] == ea[16:12]);

  p_write_has_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && prot[1]) |-> prot[0]);

  p_alt_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && alt_layout) |-> prot[2]);

  p_grant_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~match_vec) == '0));

  p_grant_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec != '0) |-> ((grant != '0) && (((grant - NUM_ENT'(1)) & match_vec) == '0)));

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (real_addr == '0 && prot == '0));

endmodule

bind blkx_match blkx_match_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ea         (ea),
  .alt_layout (alt_layout),
  .hit        (hit),
  .real_addr  (real_addr),
  .prot       (prot),
  .match_vec  (match_vec),
  .grant      (grant)
);

// File: tb/tb_blkx_match.sv
module tb_blkx_match;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_instr, wr_upper;
  logic [IW-1:0] wr_idx;
  logic [31:0]   wr_data, ea;
  logic          is_fetch, user_mode, alt_layout;
  logic          hit;
  logic [19:0]   real_addr;
  logic [2:0]    prot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] sh_up [2][N];
  logic [31:0] sh_lo [2][N];

  always #5 clk = ~clk;

  blkx_match #(.NUM_ENT(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_instr(wr_instr), .wr_idx(wr_idx),
    .wr_upper(wr_upper), .wr_data(wr_data), .ea(ea), .is_fetch(is_fetch),
    .user_mode(user_mode), .alt_layout(alt_layout), .hit(hit),
    .real_addr(real_addr), .prot(prot)
  );

  // reference model: {hit, page[19:0], prot[2:0]}
  function automatic logic [23:0] model(logic [31:0] a, bit f, bit u, bit alt);
    int s;
    s = f ? 1 : 0;
    for (int e = 0; e < N; e++) begin
      logic [31:0] up, lo, m, r;
      bit          v, key;
      logic [2:0]  p;
      int          cd;
      up = sh_up[s][e];
      lo = sh_lo[s][e];
      if (alt) begin
        v = lo[6];
        m = 32'hFFFE0000 & ~((lo & 32'h3F) << 17);
      end else begin
        v = u ? up[0] : up[1];
        m = 32'hFFFE0000 & ~((up & 32'h1FFC) << 15);
      end
      if (v && ((a & m) == (up & 32'hFFFE0000))) begin
        r = (lo & m) | (a & ~m);
        if (!alt) begin
          cd = int'(lo & 32'h3);
          p  = (cd == 0) ? 3'b000 : (cd == 2) ? 3'b111 : 3'b101;
        end else begin
          cd  = int'(up & 32'h3);
          key = u ? up[2] : up[3];
          if (!key) p = (cd == 3) ? 3'b101 : 3'b111;
          else      p = (cd == 0) ? 3'b100 : (cd == 2) ? 3'b111 : 3'b101;
        end
        return {1'b1, r[31:12], p};
      end
    end
    return 24'h0;
  endfunction

  task automatic put(input int side, input int idx, input bit upper, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = side[0]; wr_idx = IW'(idx); wr_upper = upper; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (upper) sh_up[side][idx] = d;
    else       sh_lo[side][idx] = d;
  endtask

  task automatic look_exp(input logic [31:0] a, input bit f, input bit u, input bit alt,
                          input logic [23:0] exp_v, input string req);
    logic [23:0] got;
    @(negedge clk);
    ea = a; is_fetch = f; user_mode = u; alt_layout = alt;
    #2;
    got = {hit, real_addr, prot};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s ea=%08h fetch=%0b user=%0b alt=%0b: got hit=%0b page=%05h prot=%03b, expected hit=%0b page=%05h prot=%03b",
               req, a, f, u, alt, got[23], got[22:3], got[2:0], exp_v[23], exp_v[22:3], exp_v[2:0]);
    end
  endtask

  task automatic look_mdl(input logic [31:0] a, input bit f, input bit u, input bit alt, input string req);
    look_exp(a, f, u, alt, model(a, f, u, alt), req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < N; e++) begin
        sh_up[s][e] = '0;
        sh_lo[s][e] = '0;
      end
    rst_n = 1'b0; wr_en = 1'b0; wr_instr = 1'b0; wr_idx = '0; wr_upper = 1'b0; wr_data = '0;
    ea = '0; is_fetch = 1'b0; user_mode = 1'b0; alt_layout = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: cleared bank never hits
    for (int k = 0; k < 8; k++)
      look_exp(32'h0000_0000 + k * 32'h2100_0000, k[0], k[1], k[2], 24'h0, "R1");

    // R4 and R3: supervisor-only data entry
    put(0, 0, 1'b1, 32'h1000_0002);
    put(0, 0, 1'b0, 32'h8000_0002);
    look_exp(32'h1001_2345, 0, 0, 0, {1'b1, 20'h80012, 3'b111}, "R4");
    look_exp(32'h1001_2345, 0, 1, 0, 24'h0, "R4");
    look_exp(32'h1001_2345, 1, 0, 0, 24'h0, "R3");

    // R3: instruction entry is invisible to data accesses
    put(1, 0, 1'b1, 32'h2000_0003);
    put(1, 0, 1'b0, 32'h4000_0001);
    look_exp(32'h2000_5000, 1, 0, 0, {1'b1, 20'h40005, 3'b101}, "R3");
    look_exp(32'h2000_5000, 1, 1, 0, {1'b1, 20'h40005, 3'b101}, "R3");
    look_exp(32'h2000_5000, 0, 0, 0, 24'h0, "R3");

    // R7: standard protection codes
    for (int pp = 0; pp < 4; pp++) begin
      put(0, 0, 1'b0, 32'h8000_0000 | pp);
      look_exp(32'h1000_3000, 0, 0, 0,
               {1'b1, 20'h80003, (pp == 0) ? 3'b000 : (pp == 2) ? 3'b111 : 3'b101}, "R7");
    end

    // R5 and R6: length sweep
    put(0, 0, 1'b0, 32'hA5A0_0002);
    for (int k = 0; k < 12; k++) begin
      put(0, 0, 1'b1, 32'h1000_0002 | (((32'd1 << k) - 1) << 2));
      for (int j = 0; j < 16; j++) begin
        look_mdl(32'h1000_0000 + j * 32'h0013_7000, 0, 0, 0, "R5");
        look_mdl(32'h0FFF_F000 + j * 32'h0100_0000, 0, 0, 0, "R6");
      end
    end

    // R5: base bit inside the length field never matches
    put(0, 0, 1'b1, 32'h1002_0006);
    look_exp(32'h1002_0000, 0, 0, 0, 24'h0, "R5");
    look_exp(32'h1000_0000, 0, 0, 0, 24'h0, "R5");

    // R10: overlapping entries, lowest index wins
    put(0, 0, 1'b1, 32'h0);
    put(0, 0, 1'b0, 32'h0);
    put(0, 1, 1'b1, 32'h3000_0002);
    put(0, 1, 1'b0, 32'hA000_0002);
    put(0, 2, 1'b1, 32'h3000_1FFE);
    put(0, 2, 1'b0, 32'hB000_0001);
    look_exp(32'h3001_0000, 0, 0, 0, {1'b1, 20'hA0010, 3'b111}, "R10");
    look_exp(32'h3801_0000, 0, 0, 0, {1'b1, 20'hB8010, 3'b101}, "R10");

    // R11: nothing matches
    look_exp(32'hF000_0000, 0, 0, 0, 24'h0, "R11");
    look_exp(32'hF000_0000, 1, 1, 1, 24'h0, "R11");

    // R8 and R9: alternate layout sweep
    for (int bl = 0; bl < 3; bl++)
      for (int kk = 0; kk < 16; kk++) begin
        put(0, 0, 1'b1, 32'h5000_0000 | kk);
        put(0, 0, 1'b0, 32'h9000_0040 | ((bl == 0) ? 0 : (bl == 1) ? 32'h1 : 32'h3F));
        for (int u = 0; u < 2; u++) begin
          look_mdl(32'h5000_1000, 0, u[0], 1, "R9");
          look_mdl(32'h5034_5000, 0, u[0], 1, "R8");
          look_mdl(32'h5F00_0000, 0, u[0], 1, "R8");
        end
      end
    put(0, 0, 1'b1, 32'h5000_0002);
    put(0, 0, 1'b0, 32'h9000_0001);
    look_exp(32'h5000_1000, 0, 0, 1, 24'h0, "R8");
    put(0, 0, 1'b0, 32'h9000_0040);
    look_exp(32'h5000_1000, 0, 1, 1, {1'b1, 20'h90001, 3'b111}, "R9");

    // R2: single-word writes leave neighbours intact
    put(1, 1, 1'b0, 32'hD000_0002);
    put(1, 1, 1'b1, 32'h6000_0003);
    look_exp(32'h6000_0000, 1, 0, 0, {1'b1, 20'hD0000, 3'b111}, "R2");
    look_exp(32'h6000_0000, 0, 0, 0, 24'h0, "R2");
    put(1, 1, 1'b1, 32'h6000_0001);
    look_exp(32'h6000_0000, 1, 0, 0, 24'h0, "R2");
    look_exp(32'h6000_0000, 1, 1, 0, {1'b1, 20'hD0000, 3'b111}, "R2");
    look_exp(32'h2000_5000, 1, 0, 0, {1'b1, 20'h40005, 3'b101}, "R2");

    // R3: cross-check both sets under all modes
    for (int c = 0; c < 8; c++)
      for (int j = 0; j < 8; j++)
        look_mdl(32'h1000_0000 * j + 32'h0001_3000, c[0], c[1], c[2], "R3");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule